// File: doc/BRIEF.md
# Separable Polyphase Image Scaler

This block resamples a raster image that arrives one pixel at a time. Run-time size inputs give the source size (M columns by N rows) and the target size (X columns by Y rows). The block works out each target pixel with two one-dimensional four-tap polyphase filters in cascade. The vertical filter runs first and gives an intermediate value for each source column. The horizontal filter then combines four intermediates into the result. The whole kernel therefore uses eight multipliers, where a full two-dimensional kernel would use sixteen.

Incoming lines are stored in rotation in four line buffers, each as wide as the widest source line. Once a source line completes every window that an output row needs, the block emits that output row and then goes back to accepting input. Both edges use a valid/ready handshake. A start-of-frame flag marks the first pixel and an end-of-line flag marks the last pixel of each line.

Top module: `polyScaler`

## Requirements
- R1: After reset the block has `outValid` low and `inReady` high.
- R2: Each frame yields exactly X·Y output pixels in raster order. `outSof` is set only on the first of them and `outEol` only on the last pixel of each output row.
- R3: The step is floor(size_in·65536/size_out) for each axis. Output column x maps to source position x·stepX and output row y maps to y·stepY. Bits 27:16 of the position give the centre index and bits 15:12 give the phase (0..15).
- R4: The window of a centre index c covers source indices c−2, c−1, c, c+1, taken as taps 0 to 3. An index outside the picture is replaced by the nearest edge index, so edge pixels are repeated.
- R5: The weights for phase p and taps 0 to 3 are −p, 16, 496−32p and 33p. They add up to 512, so a uniform image passes through unchanged.
- R6: Vertical filtering runs first for each needed column. Its sum is rounded as (sum+256)>>>9 and clamped to 0..255. The horizontal filter works on these clamped intermediates and applies the same rounding and clamping.
- R7: While `outValid` is high and `outReady` is low, `outValid`, `outData`, `outSof` and `outEol` stay unchanged.
- R8: An input pixel is taken only on a cycle with `inValid` and `inReady` both high, and gaps in `inValid` do not change the result. `inReady` is low whenever an output pixel is pending, and it is low in the cycle after an end-of-line pixel is taken.
- R9: The four size inputs are sampled only with the start-of-frame pixel. Changes to them later in the frame do not affect that frame's output.
- R10: Any ratio within the sizes is handled, both enlargement and reduction. In a reduction, source lines that no window uses are accepted and dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgInWidth | input | 12 | Source columns M |
| cfgInHeight | input | 12 | Source rows N |
| cfgOutWidth | input | 12 | Target columns X |
| cfgOutHeight | input | 12 | Target rows Y |
| inValid | input | 1 | Input pixel present |
| inReady | output | 1 | Block can take an input pixel |
| inData | input | 8 | Input pixel value |
| inSof | input | 1 | First pixel of a frame |
| inEol | input | 1 | Last pixel of a line |
| outValid | output | 1 | Output pixel present |
| outReady | input | 1 | Sink takes the output pixel |
| outData | output | 8 | Output pixel value |
| outSof | output | 1 | First output pixel of a frame |
| outEol | output | 1 | Last output pixel of a row |

## Verification
A uniform frame shows whether the weights and rounding keep the DC level exactly. A gradient enlargement checks the position and phase arithmetic and the edge repetition. A pseudo-random reduction checks that lines and columns are skipped correctly. A striped frame drives both stage sums past 0 and 255, so the clamp is exercised. A tiny three-by-two source makes almost every window reach outside the picture. Runs with input gaps and output stalls, and a run that changes the size inputs during a frame, separate handshake and sampling faults from arithmetic faults.

// File: rtl/scalerPkg.sv
package scalerPkg;
  localparam int TAPS       = 4;
  localparam int PH_W       = 4;
  localparam int COEF_W     = 10;
  localparam int PIX_W      = 8;
  localparam int DIM_W      = 12;
  localparam int FRAC_W     = 16;
  localparam int POS_W      = DIM_W + FRAC_W;
  localparam int SLOT_W     = $clog2(TAPS);
  localparam int MAC_W      = 22;
  localparam int NORM_SHIFT = 9;
  localparam logic signed [MAC_W-1:0] ROUND_HALF = MAC_W'(1) << (NORM_SHIFT - 1);
  localparam logic signed [MAC_W-1:0] PIX_MAX    = MAC_W'((1 << PIX_W) - 1);

  typedef logic [PIX_W-1:0] pix_t;

  // strobes from control to datapath
  typedef struct packed {
    logic                         wrEn;
    logic [SLOT_W-1:0]            wrSlot;
    logic [DIM_W-1:0]             wrCol;
    logic [DIM_W-1:0]             rdCol;
    logic [TAPS-1:0][SLOT_W-1:0]  rowSlot;
    logic [PH_W-1:0]              vPhase;
    logic [PH_W-1:0]              hPhase;
    logic                         vShift;
    logic                         hLoad;
  } strobe_t;

  // weight of one tap for one phase; the four weights add up to 512
  function automatic logic signed [COEF_W-1:0] coefOf(input logic [PH_W-1:0] ph, input int tap);
    int a;
    int c;
    a = int'(ph);
    case (tap)
      0:       c = -a;
      1:       c = 16;
      2:       c = 496 - 32 * a;
      default: c = 33 * a;
    endcase
    return COEF_W'(c);
  endfunction

  function automatic pix_t roundClamp(input logic signed [MAC_W-1:0] acc);
    logic signed [MAC_W-1:0] s;
    s = (acc + ROUND_HALF) >>> NORM_SHIFT;
    if (s < 0) return '0;
    if (s > PIX_MAX) return '1;
    return s[PIX_W-1:0];
  endfunction
endpackage

// File: rtl/scalerDatapath.sv
module scalerDatapath
  import scalerPkg::*;
#(
  parameter int MAX_WIDTH = 64
) (
  input  logic    clk,
  input  logic    rst,
  input  strobe_t stb,
  input  pix_t    inData,
  output pix_t    outData
);
  localparam int LB_AW = $clog2(MAX_WIDTH);

  pix_t rdAll [TAPS];
  logic [LB_AW-1:0] wrIdx, rdIdx;
  logic wrInRange;

  assign wrInRange = stb.wrCol < DIM_W'(MAX_WIDTH);
  assign wrIdx = wrInRange ? stb.wrCol[LB_AW-1:0] : '0;
  assign rdIdx = (stb.rdCol < DIM_W'(MAX_WIDTH)) ? stb.rdCol[LB_AW-1:0] : '0;

  // one line buffer per slot, registered read
  for (genvar s = 0; s < TAPS; s++) begin : g_line
    pix_t mem [MAX_WIDTH];
    pix_t rd;
    always_ff @(posedge clk) begin
      if (stb.wrEn && wrInRange && stb.wrSlot == SLOT_W'(s)) mem[wrIdx] <= inData;
      rd <= mem[rdIdx];
    end
    assign rdAll[s] = rd;
  end

  // vertical stage: one multiplier per tap
  logic signed [MAC_W-1:0] vProd [TAPS];
  logic signed [MAC_W-1:0] hProd [TAPS];
  logic signed [MAC_W-1:0] vSum, hSum;
  pix_t vTap [TAPS];

  for (genvar j = 0; j < TAPS; j++) begin : g_vmul
    logic signed [COEF_W-1:0] coef;
    logic signed [MAC_W-1:0]  coefX, pixX;
    assign coef  = coefOf(stb.vPhase, j);
    assign coefX = {{(MAC_W-COEF_W){coef[COEF_W-1]}}, coef};
    assign pixX  = {{(MAC_W-PIX_W){1'b0}}, rdAll[stb.rowSlot[j]]};
    assign vProd[j] = coefX * pixX;
  end

  // horizontal stage: one multiplier per tap
  for (genvar i = 0; i < TAPS; i++) begin : g_hmul
    logic signed [COEF_W-1:0] coef;
    logic signed [MAC_W-1:0]  coefX, pixX;
    assign coef  = coefOf(stb.hPhase, i);
    assign coefX = {{(MAC_W-COEF_W){coef[COEF_W-1]}}, coef};
    assign pixX  = {{(MAC_W-PIX_W){1'b0}}, vTap[i]};
    assign hProd[i] = coefX * pixX;
  end

  always_comb begin
    vSum = '0;
    hSum = '0;
    for (int k = 0; k < TAPS; k++) begin
      vSum = vSum + vProd[k];
      hSum = hSum + hProd[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TAPS; k++) vTap[k] <= '0;
      outData <= '0;
    end else begin
      if (stb.vShift) begin
        for (int k = 0; k < TAPS - 1; k++) vTap[k] <= vTap[k+1];
        vTap[TAPS-1] <= roundClamp(vSum);
      end
      if (stb.hLoad) outData <= roundClamp(hSum);
    end
  end
endmodule

// File: rtl/scalerControl.sv
module scalerControl
  import scalerPkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [DIM_W-1:0] cfgInWidth,
  input  logic [DIM_W-1:0] cfgInHeight,
  input  logic [DIM_W-1:0] cfgOutWidth,
  input  logic [DIM_W-1:0] cfgOutHeight,
  input  logic             inValid,
  input  logic             inSof,
  input  logic             inEol,
  output logic             inReady,
  output logic             outValid,
  input  logic             outReady,
  output logic             outSof,
  output logic             outEol,
  output strobe_t          stb
);
  localparam int CNT_W = $clog2(TAPS + 1);

  typedef enum logic [2:0] {ST_ACCEPT, ST_ROWCHK, ST_COLLECT, ST_HFILT, ST_EMIT} state_t;

  state_t state;
  logic [DIM_W-1:0] inW, inH, outW, outH;
  logic [DIM_W-1:0] inCol, inRow, lastRow, outX, outY;
  logic [POS_W-1:0] stepX, stepY, hPos, vPos;
  logic [CNT_W-1:0] tapCnt;
  logic [TAPS-1:0][SLOT_W-1:0] rowSlotR, rowSlotNext;

  logic accept;
  logic [DIM_W-1:0] pixCol, pixRow, iy, ix, need, lastIdx;
  logic [DIM_W:0] iyPlus;
  logic [POS_W-1:0] stepXNew, stepYNew;

  function automatic logic [DIM_W-1:0] clampIdx(input int idx, input logic [DIM_W-1:0] size);
    if (idx < 0) return '0;
    if (idx > int'(size) - 1) return size - 1'b1;
    return DIM_W'(idx);
  endfunction

  assign inReady  = (state == ST_ACCEPT);
  assign outValid = (state == ST_EMIT);
  assign outSof   = outValid && outX == '0 && outY == '0;
  assign outEol   = outValid && outX == outW - 1'b1;

  assign accept   = inValid && inReady;
  assign pixCol   = inSof ? '0 : inCol;
  assign pixRow   = inSof ? '0 : inRow;
  assign iy       = vPos[POS_W-1:FRAC_W];
  assign ix       = hPos[POS_W-1:FRAC_W];
  assign iyPlus   = {1'b0, iy} + 1'b1;
  assign lastIdx  = inH - 1'b1;
  assign need     = (iyPlus > {1'b0, lastIdx}) ? lastIdx : iyPlus[DIM_W-1:0];
  assign stepXNew = {cfgInWidth, {FRAC_W{1'b0}}} / POS_W'(cfgOutWidth);
  assign stepYNew = {cfgInHeight, {FRAC_W{1'b0}}} / POS_W'(cfgOutHeight);

  always_comb begin
    for (int j = 0; j < TAPS; j++) begin
      logic [DIM_W-1:0] r;
      r = clampIdx(int'(iy) - TAPS / 2 + j, inH);
      rowSlotNext[j] = r[SLOT_W-1:0];
    end
  end

  always_comb begin
    stb         = '0;
    stb.wrEn    = accept;
    stb.wrSlot  = pixRow[SLOT_W-1:0];
    stb.wrCol   = pixCol;
    stb.rdCol   = clampIdx(int'(ix) - TAPS / 2 + int'(tapCnt), inW);
    stb.rowSlot = rowSlotR;
    stb.vPhase  = vPos[FRAC_W-1 -: PH_W];
    stb.hPhase  = hPos[FRAC_W-1 -: PH_W];
    stb.vShift  = (state == ST_COLLECT) && tapCnt != '0;
    stb.hLoad   = (state == ST_HFILT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_ACCEPT;
      inW <= '0; inH <= '0; outW <= '0; outH <= '0;
      inCol <= '0; inRow <= '0; lastRow <= '0; outX <= '0; outY <= '0;
      stepX <= '0; stepY <= '0; hPos <= '0; vPos <= '0;
      tapCnt <= '0;
      rowSlotR <= '0;
    end else begin
      case (state)
        ST_ACCEPT: if (accept) begin
          if (inSof) begin
            inW <= cfgInWidth;   inH <= cfgInHeight;
            outW <= cfgOutWidth; outH <= cfgOutHeight;
            stepX <= stepXNew;   stepY <= stepYNew;
            vPos <= '0;          outY <= '0;
          end
          if (inEol) begin
            inCol   <= '0;
            inRow   <= pixRow + 1'b1;
            lastRow <= pixRow;
            state   <= ST_ROWCHK;
          end else begin
            inCol <= pixCol + 1'b1;
            inRow <= pixRow;
          end
        end
        ST_ROWCHK: begin
          if (outY < outH && need <= lastRow) begin
            rowSlotR <= rowSlotNext;
            outX <= '0; hPos <= '0; tapCnt <= '0;
            state <= ST_COLLECT;
          end else begin
            state <= ST_ACCEPT;
          end
        end
        ST_COLLECT: begin
          if (tapCnt == CNT_W'(TAPS)) begin
            tapCnt <= '0;
            state  <= ST_HFILT;
          end else begin
            tapCnt <= tapCnt + 1'b1;
          end
        end
        ST_HFILT: state <= ST_EMIT;
        ST_EMIT: if (outReady) begin
          if (outX == outW - 1'b1) begin
            outY  <= outY + 1'b1;
            vPos  <= vPos + stepY;
            state <= ST_ROWCHK;
          end else begin
            outX  <= outX + 1'b1;
            hPos  <= hPos + stepX;
            state <= ST_COLLECT;
          end
        end
        default: state <= ST_ACCEPT;
      endcase
    end
  end
endmodule

// File: rtl/polyScaler.sv
module polyScaler
  import scalerPkg::*;
#(
  parameter int MAX_WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIM_W-1:0] cfgInWidth,
  input  logic [DIM_W-1:0] cfgInHeight,
  input  logic [DIM_W-1:0] cfgOutWidth,
  input  logic [DIM_W-1:0] cfgOutHeight,
  input  logic             inValid,
  output logic             inReady,
  input  logic [PIX_W-1:0] inData,
  input  logic             inSof,
  input  logic             inEol,
  output logic             outValid,
  input  logic             outReady,
  output logic [PIX_W-1:0] outData,
  output logic             outSof,
  output logic             outEol
);
  strobe_t stb;

  scalerControl i_control (
    .clk(clk), .rst(rst),
    .cfgInWidth(cfgInWidth), .cfgInHeight(cfgInHeight),
    .cfgOutWidth(cfgOutWidth), .cfgOutHeight(cfgOutHeight),
    .inValid(inValid), .inSof(inSof), .inEol(inEol), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .outSof(outSof), .outEol(outEol),
    .stb(stb)
  );

  scalerDatapath #(.MAX_WIDTH(MAX_WIDTH)) i_datapath (
    .clk(clk), .rst(rst), .stb(stb), .inData(inData), .outData(outData)
  );
endmodule

// File: rtl/polyScalerChecker.sv
module polyScalerChecker
  import scalerPkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             inReady,
  input logic             inEol,
  input logic             outValid,
  input logic             outReady,
  input logic [PIX_W-1:0] outData,
  input logic             outSof,
  input logic             outEol
);
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> inReady && !outValid); // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outSof) && $stable(outEol)); // R7

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    outValid |-> !inReady); // R8

  AST_LINE_PAUSE: assert property (@(posedge clk) disable iff (rst)
    inValid && inReady && inEol |=> !inReady); // R8
endmodule

bind polyScaler polyScalerChecker i_checker (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inEol(inEol),
  .outValid(outValid), .outReady(outReady), .outData(outData),
  .outSof(outSof), .outEol(outEol)
);

// File: tb/test_polyScaler.sv
module test_polyScaler;
  localparam int CLK_PERIOD = 10;
  localparam int MAXD = 64;
  localparam int FRAME_LIMIT = 40000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [11:0] cfgInWidth = '0, cfgInHeight = '0, cfgOutWidth = '0, cfgOutHeight = '0;
  logic inValid = 1'b0, inSof = 1'b0, inEol = 1'b0, outReady = 1'b0;
  logic [7:0] inData = '0;
  logic inReady, outValid, outSof, outEol;
  logic [7:0] outData;

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  int img [MAXD][MAXD];
  int expPix [MAXD*MAXD];

  always #(CLK_PERIOD/2) clk = ~clk;

  polyScaler i_polyScaler (
    .clk(clk), .rst(rst),
    .cfgInWidth(cfgInWidth), .cfgInHeight(cfgInHeight),
    .cfgOutWidth(cfgOutWidth), .cfgOutHeight(cfgOutHeight),
    .inValid(inValid), .inReady(inReady), .inData(inData), .inSof(inSof), .inEol(inEol),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outSof(outSof), .outEol(outEol)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // R5 weights
  function automatic int weight(int p, int t);
    case (t)
      0: return -p;
      1: return 16;
      2: return 496 - 32 * p;
      default: return 33 * p;
    endcase
  endfunction

  // R6 rounding and clamp
  function automatic int rc(int a);
    int s = (a + 256) >>> 9;
    if (s < 0) return 0;
    if (s > 255) return 255;
    return s;
  endfunction

  // R4 edge repetition
  function automatic int edgeIdx(int v, int n);
    if (v < 0) return 0;
    if (v > n - 1) return n - 1;
    return v;
  endfunction

  // R3 mapping, R6 cascade
  function automatic void buildExpected(int m, int n, int x, int y);
    int sx = (m * 65536) / x;
    int sy = (n * 65536) / y;
    int mid [MAXD];
    for (int oy = 0; oy < y; oy++) begin
      int py = oy * sy;
      int cy = py >> 16;
      int vp = (py >> 12) & 15;
      for (int c = 0; c < m; c++) begin
        int acc = 0;
        for (int j = 0; j < 4; j++) acc += weight(vp, j) * img[edgeIdx(cy - 2 + j, n)][c];
        mid[c] = rc(acc);
      end
      for (int ox = 0; ox < x; ox++) begin
        int px = ox * sx;
        int cx = px >> 16;
        int hp = (px >> 12) & 15;
        int acc = 0;
        for (int i = 0; i < 4; i++) acc += weight(hp, i) * mid[edgeIdx(cx - 2 + i, m)];
        expPix[oy * x + ox] = rc(acc);
      end
    end
  endfunction

  task automatic driveFrame(int m, int n, bit bubble, bit twist);
    for (int r = 0; r < n; r++) begin
      for (int c = 0; c < m; c++) begin
        if (bubble && ((r + c) % 3 == 0)) begin
          @(negedge clk);
          inValid = 1'b0;
        end
        @(negedge clk);
        if (twist && r == 0 && c == 1) begin
          cfgInWidth = 12'd10; cfgInHeight = 12'd3; cfgOutWidth = 12'd4; cfgOutHeight = 12'd2;
        end
        inValid = 1'b1;
        inData  = 8'(img[r][c]);
        inSof   = (r == 0 && c == 0);
        inEol   = (c == m - 1);
        while (!inReady) @(negedge clk);
      end
    end
    @(negedge clk);
    inValid = 1'b0; inSof = 1'b0; inEol = 1'b0;
  endtask

  task automatic collectFrame(int x, int y, bit stall, string req);
    int beats = 0, dataErr = 0, flagErr = 0, stabErr = 0;
    int badIdx = -1, badAct = 0, badExp = 0, extra = 0;
    bit prevStalled = 0;
    logic [7:0] prevData = '0;
    int cyc = 0;
    while (beats < x * y && cyc < FRAME_LIMIT) begin
      bit rdy;
      @(negedge clk);
      cyc++;
      rdy = !stall || (cyc % 3 != 0);
      if (prevStalled && (!outValid || outData != prevData)) stabErr++;
      if (outValid && rdy) begin
        if (int'(outData) != expPix[beats]) begin
          dataErr++;
          if (badIdx < 0) begin badIdx = beats; badAct = int'(outData); badExp = expPix[beats]; end
        end
        if (outSof != (beats == 0) || outEol != ((beats % x) == x - 1)) flagErr++;
        beats++;
      end
      prevStalled = outValid && !rdy;
      prevData = outData;
      outReady = rdy;
    end
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      outReady = 1'b1;
      if (outValid) extra++;
    end
    check(beats == x * y && extra == 0, "R2", "output pixel count", beats + extra, x * y);
    check(flagErr == 0, "R2", "sof/eol flag errors", flagErr, 0);
    check(dataErr == 0, req, $sformatf("pixel data at index %0d", badIdx), badAct, badExp);
    if (stall) check(stabErr == 0, "R7", "changes while stalled", stabErr, 0);
  endtask

  task automatic runCase(int m, int n, int x, int y, bit bubble, bit stall, bit twist, string req);
    @(negedge clk);
    cfgInWidth = 12'(m); cfgInHeight = 12'(n); cfgOutWidth = 12'(x); cfgOutHeight = 12'(y);
    buildExpected(m, n, x, y);
    fork
      driveFrame(m, n, bubble, twist);
      collectFrame(x, y, stall, req);
    join
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(inReady == 1'b1, "R1", "inReady after reset", int'(inReady), 1);
    check(outValid == 1'b0, "R1", "outValid after reset", int'(outValid), 0);
  endtask

  task automatic testFlat();  // R5 uniform level preserved
    for (int r = 0; r < MAXD; r++) for (int c = 0; c < MAXD; c++) img[r][c] = 100;
    runCase(5, 4, 9, 7, 0, 0, 0, "R5");
  endtask

  task automatic testUpscale();  // R3 R4 R10 gradient enlargement
    for (int r = 0; r < MAXD; r++) for (int c = 0; c < MAXD; c++) img[r][c] = (r * 20 + c * 9) % 256;
    runCase(6, 5, 11, 9, 0, 0, 0, "R3");
  endtask

  task automatic testDownscale();  // R10 reduction skips lines
    for (int r = 0; r < MAXD; r++) for (int c = 0; c < MAXD; c++) img[r][c] = (r * 37 + c * 53 + 11) % 256;
    runCase(16, 12, 6, 5, 0, 0, 0, "R10");
  endtask

  task automatic testClamp();  // R6 stripes push sums past both limits
    for (int r = 0; r < MAXD; r++) for (int c = 0; c < MAXD; c++)
      img[r][c] = (((c % 2) == 1) ^ ((r % 3) == 0)) ? 255 : 0;
    runCase(7, 7, 12, 10, 0, 0, 0, "R6");
  endtask

  task automatic testTinyEdges();  // R4 nearly all windows reach outside
    for (int r = 0; r < MAXD; r++) for (int c = 0; c < MAXD; c++) img[r][c] = (r == 0) ? 40 + c * 80 : 220 - c * 60;
    runCase(3, 2, 7, 5, 0, 0, 0, "R4");
  endtask

  task automatic testHandshake();  // R7 R8 input gaps and output stalls
    for (int r = 0; r < MAXD; r++) for (int c = 0; c < MAXD; c++) img[r][c] = (r * 71 + c * c * 5) % 256;
    runCase(8, 6, 13, 9, 1, 1, 0, "R8");
  endtask

  task automatic testCfgLatch();  // R9 size inputs change mid-frame
    for (int r = 0; r < MAXD; r++) for (int c = 0; c < MAXD; c++) img[r][c] = (r * 13 + c * 29) % 256;
    runCase(6, 6, 9, 8, 0, 0, 1, "R9");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    testReset();
    testFlat();
    testUpscale();
    testDownscale();
    testClamp();
    testTinyEdges();
    testHandshake();
    testCfgLatch();
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule